// File: doc/BRIEF.md
# DisplayPort Link Training Sequencer

This block is the source-side controller that brings a DisplayPort main link up. A register-access request port stands in for the AUX channel. On that port the block issues one write or read at a time. Each request carries an address and a data byte. The request stays up until the far side pulses `req_done`, and `req_ack` says whether the sink accepted it. Once started, the block programs the link rate and lane count. It then runs the clock-recovery phase with training pattern 1, followed by the channel-equalization phase with a selectable higher pattern. In both phases it polls the sink's lane status registers.

A programmable gap separates each pattern write from the status read that follows it, and also separates one poll from the next. Each phase may make at most a fixed number of polls. When a phase uses up its polls, the block first clears the pattern and then drops one step in link rate. It reports `link_trained` when equalization completes, and `train_failed` when the lowest rate also fails. Both verdicts stay asserted until the next start.

Top module: `link_train_seq`

## Requirements
- R1: After reset, `link_trained`, `train_failed` and `req_valid` are all low, and no request is issued until `start` is pulsed.
- R2: A training attempt opens with a write of the rate code to address 0x100 and then a write of the lane count (1, 2 or 4) to address 0x101, before any pattern write. The rate codes are 0x14 for 5.4 Gb/s (index 0), 0x0A for 2.7 Gb/s (index 1) and 0x06 for 1.62 Gb/s (index 2). `cfg_rate` selects the starting index.
- R3: Clock recovery at each rate begins with a write of 1 to the pattern register at address 0x102.
- R4: A status read never starts fewer than `poll_gap` cycles after the preceding pattern write or poll has completed.
- R5: A poll reads 0x202, 0x203 and 0x204, in that order. In these bytes, lane k has a status nibble: lanes 0 and 1 are in 0x202 at bits [3:0] and [7:4], and lanes 2 and 3 are in 0x203 at the same positions. Within a nibble, bit 0 means clock recovery done, bit 1 means equalization done and bit 2 means symbol locked. Bit 0 of 0x204 means inter-lane alignment. Lanes beyond the configured count are ignored.
- R6: As soon as a poll shows clock recovery done on every active lane, the next request writes the equalization pattern (`cfg_eq_tps`: 2, 3 or 4; any other value selects 3) to 0x102.
- R7: Each phase allows at most 5 polls. When all 5 fail, the block writes 0 to 0x102 before it changes the rate, and the lower rate restarts with pattern 1.
- R8: The rate falls back from index 0 to 1 to 2 only. Failure at index 2 asserts `train_failed`, with the pattern left at 0.
- R9: Equalization passes when every active lane shows clock recovery, equalization done and symbol lock, and alignment is set. The block then writes 0 to 0x102 and asserts `link_trained` at the rate reached, which `rate_idx` shows.
- R10: Only one request is outstanding at a time. While `req_valid` is high and `req_done` is low, the command, address and data hold steady.
- R11: A status read that completes with `req_ack` low makes that whole poll a failure, whatever data it returned.
- R12: `link_trained` and `train_failed` are never high together. Each holds until the next `start`, which clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin training; accepted when not busy |
| cfg_lanes | input | 3 | Lane count: 1, 2, or 4 (other values mean 4) |
| cfg_rate | input | 2 | Starting rate index (3 means 2) |
| cfg_eq_tps | input | 3 | Equalization pattern number |
| poll_gap | input | GAP_W | Idle cycles before each status poll |
| req_valid | output | 1 | Request pending |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | ADDR_W | Register address |
| req_wdata | output | 8 | Write data |
| req_done | input | 1 | Single-cycle completion of the pending request |
| req_ack | input | 1 | Completion status, 0 = NACK or timeout |
| rsp_rdata | input | 8 | Read data, valid with `req_done` |
| link_trained | output | 1 | Training succeeded |
| train_failed | output | 1 | Training failed at the lowest rate |
| rate_idx | output | 2 | Current or final rate index |

## Verification
The assertions assume the responder raises `req_done` only while `req_valid` is high, for exactly one cycle per request. They also assume that `poll_gap` and the configuration inputs stay fixed during a run, and that `start` arrives only once a verdict is showing.

The bench responder model answers after a fixed latency and drops `req_done` on the next cycle. Status bytes are derived from the attempt count within each phase, and lanes outside the configuration report zeros. A new run is started only after the verdict has been observed, so the stimulus stays inside these assumptions.

// File: rtl/lt_pkg.sv
package lt_pkg;

  localparam int LANES_MAX = 4;

  localparam logic [19:0] A_RATE  = 20'h00100;
  localparam logic [19:0] A_LANES = 20'h00101;
  localparam logic [19:0] A_TPS   = 20'h00102;
  localparam logic [19:0] A_ST01  = 20'h00202;
  localparam logic [19:0] A_ST23  = 20'h00203;
  localparam logic [19:0] A_ALIGN = 20'h00204;

  typedef enum logic [3:0] {
    S_IDLE, S_WR_RATE, S_WR_LANES, S_WR_TPS, S_GAP,
    S_RD0, S_RD1, S_RD2, S_EVAL, S_WR_CLR, S_NEXT, S_OK, S_FAIL
  } lt_state_t;

  function automatic logic [7:0] rate_code(input logic [1:0] idx);
    case (idx)
      2'd0:    rate_code = 8'h14;
      2'd1:    rate_code = 8'h0A;
      default: rate_code = 8'h06;
    endcase
  endfunction

  function automatic logic [1:0] rate_clamp(input logic [1:0] idx);
    rate_clamp = (idx == 2'd3) ? 2'd2 : idx;
  endfunction

  function automatic logic [2:0] lane_norm(input logic [2:0] n);
    case (n)
      3'd1:    lane_norm = 3'd1;
      3'd2:    lane_norm = 3'd2;
      default: lane_norm = 3'd4;
    endcase
  endfunction

  function automatic logic [LANES_MAX-1:0] lane_mask(input logic [2:0] n);
    case (n)
      3'd1:    lane_mask = 4'b0001;
      3'd2:    lane_mask = 4'b0011;
      default: lane_mask = 4'b1111;
    endcase
  endfunction

  function automatic logic [2:0] eq_tps_sel(input logic [2:0] p);
    eq_tps_sel = (p == 3'd2 || p == 3'd3 || p == 3'd4) ? p : 3'd3;
  endfunction

endpackage

// File: rtl/lt_lane_eval.sv
module lt_lane_eval #(
  parameter int LANES = 4
) (
  input  logic [7:0]       st01,
  input  logic [7:0]       st23,
  input  logic             align,
  input  logic [LANES-1:0] mask,
  output logic             cr_ok,
  output logic             eq_ok
);
  logic [LANES-1:0] cr_l, eq_l;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [3:0] nib;
    if (g < 2) begin : g_lo
      assign nib = st01[g*4 +: 4];
    end else begin : g_hi
      assign nib = st23[(g-2)*4 +: 4];
    end
    assign cr_l[g] = nib[0] | ~mask[g];
    assign eq_l[g] = (nib[1] & nib[2]) | ~mask[g];
  end

  assign cr_ok = &cr_l;
  assign eq_ok = (&cr_l) & (&eq_l) & align;
endmodule

// File: rtl/lt_gap_timer.sv
module lt_gap_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load)            cnt_q <= len;
    else if (cnt_q != '0)     cnt_q <= cnt_q - W'(1);
  end

  assign expired = (cnt_q == '0) && !load;
endmodule

// File: rtl/lt_poll_ctr.sv
module lt_poll_ctr #(
  parameter int MAX = 5,
  parameter int CW  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt,
  output logic          last
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (inc)  cnt <= cnt + CW'(1);
  end

  assign last = (cnt == CW'(MAX - 1));
endmodule

// File: rtl/link_train_seq.sv
module link_train_seq
  import lt_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int MAX_POLLS = 5,
  parameter int GAP_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        cfg_lanes,
  input  logic [1:0]        cfg_rate,
  input  logic [2:0]        cfg_eq_tps,
  input  logic [GAP_W-1:0]  poll_gap,
  output logic              req_valid,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [7:0]        req_wdata,
  input  logic              req_done,
  input  logic              req_ack,
  input  logic [7:0]        rsp_rdata,
  output logic              link_trained,
  output logic              train_failed,
  output logic [1:0]        rate_idx
);
  localparam int         CNT_W     = $clog2(MAX_POLLS + 1);
  localparam logic [1:0] RATE_LAST = 2'd2;

  lt_state_t st_q, st_d;
  logic       eq_phase_q, win_q, nack_q, align_q;
  logic [1:0] rate_q;
  logic [2:0] lanes_q, eqtps_q;
  logic [7:0] st01_q, st23_q, tps_now_q;
  logic [19:0] addr20;
  logic [7:0]  wdata;

  // named internal events
  logic             xfer_done, start_evt, fallback_evt, gap_ok, pass;
  logic             tmr_load, poll_clr, poll_inc, poll_last, cr_ok, eq_ok;
  logic [CNT_W-1:0] poll_cnt;

  assign xfer_done    = req_valid && req_done;
  assign start_evt    = start && (st_q == S_IDLE || st_q == S_OK || st_q == S_FAIL);
  assign fallback_evt = (st_q == S_NEXT) && (rate_q != RATE_LAST);
  assign pass         = !nack_q && (eq_phase_q ? eq_ok : cr_ok);

  lt_lane_eval #(.LANES(LANES_MAX)) u_eval (
    .st01 (st01_q), .st23 (st23_q), .align (align_q),
    .mask (lane_mask(lanes_q)), .cr_ok (cr_ok), .eq_ok (eq_ok)
  );

  lt_gap_timer #(.W(GAP_W)) u_gap (
    .clk (clk), .rst_n (rst_n), .load (tmr_load), .len (poll_gap), .expired (gap_ok)
  );

  lt_poll_ctr #(.MAX(MAX_POLLS), .CW(CNT_W)) u_polls (
    .clk (clk), .rst_n (rst_n), .clr (poll_clr), .inc (poll_inc),
    .cnt (poll_cnt), .last (poll_last)
  );

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    poll_clr = 1'b0;
    poll_inc = 1'b0;
    unique case (st_q)
      S_IDLE, S_OK, S_FAIL: if (start) st_d = S_WR_RATE;
      S_WR_RATE:  if (xfer_done) st_d = S_WR_LANES;
      S_WR_LANES: if (xfer_done) st_d = S_WR_TPS;
      S_WR_TPS: if (xfer_done) begin
        st_d     = S_GAP;
        tmr_load = 1'b1;
        poll_clr = 1'b1;
      end
      S_GAP: if (gap_ok) st_d = S_RD0;
      S_RD0: if (xfer_done) st_d = S_RD1;
      S_RD1: if (xfer_done) st_d = S_RD2;
      S_RD2: if (xfer_done) st_d = S_EVAL;
      S_EVAL: begin
        if (pass) begin
          st_d = eq_phase_q ? S_WR_CLR : S_WR_TPS;
        end else begin
          poll_inc = 1'b1;
          if (poll_last) st_d = S_WR_CLR;
          else begin
            st_d     = S_GAP;
            tmr_load = 1'b1;
          end
        end
      end
      S_WR_CLR: if (xfer_done) st_d = win_q ? S_OK : S_NEXT;
      S_NEXT:   st_d = (rate_q == RATE_LAST) ? S_FAIL : S_WR_RATE;
      default:  st_d = S_IDLE;
    endcase
  end

  always_comb begin
    addr20 = A_TPS;
    wdata  = 8'h00;
    case (st_q)
      S_WR_RATE:  begin addr20 = A_RATE;  wdata = rate_code(rate_q); end
      S_WR_LANES: begin addr20 = A_LANES; wdata = {5'd0, lanes_q}; end
      S_WR_TPS:   begin addr20 = A_TPS;   wdata = eq_phase_q ? {5'd0, eqtps_q} : 8'h01; end
      S_WR_CLR:   begin addr20 = A_TPS;   wdata = 8'h00; end
      S_RD0:      addr20 = A_ST01;
      S_RD1:      addr20 = A_ST23;
      S_RD2:      addr20 = A_ALIGN;
      default:    addr20 = A_TPS;
    endcase
  end

  assign req_valid = (st_q == S_WR_RATE) || (st_q == S_WR_LANES) || (st_q == S_WR_TPS) ||
                     (st_q == S_WR_CLR)  || (st_q == S_RD0) || (st_q == S_RD1) || (st_q == S_RD2);
  assign req_write = (st_q == S_WR_RATE) || (st_q == S_WR_LANES) || (st_q == S_WR_TPS) ||
                     (st_q == S_WR_CLR);
  assign req_addr  = ADDR_W'(addr20);
  assign req_wdata = wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      eq_phase_q <= 1'b0;
      win_q      <= 1'b0;
      nack_q     <= 1'b0;
      align_q    <= 1'b0;
      rate_q     <= 2'd0;
      lanes_q    <= 3'd4;
      eqtps_q    <= 3'd3;
      st01_q     <= 8'h00;
      st23_q     <= 8'h00;
      tps_now_q  <= 8'h00;
    end else begin
      st_q <= st_d;
      if (start_evt) begin
        rate_q     <= rate_clamp(cfg_rate);
        lanes_q    <= lane_norm(cfg_lanes);
        eqtps_q    <= eq_tps_sel(cfg_eq_tps);
        eq_phase_q <= 1'b0;
        win_q      <= 1'b0;
      end
      if (fallback_evt) begin
        rate_q     <= rate_q + 2'd1;
        eq_phase_q <= 1'b0;
      end
      if (st_q == S_EVAL && pass) begin
        if (eq_phase_q) win_q      <= 1'b1;
        else            eq_phase_q <= 1'b1;
      end
      if (st_q == S_GAP) nack_q <= 1'b0;
      if (xfer_done) begin
        case (st_q)
          S_RD0: begin st01_q  <= rsp_rdata;    nack_q <= nack_q | ~req_ack; end
          S_RD1: begin st23_q  <= rsp_rdata;    nack_q <= nack_q | ~req_ack; end
          S_RD2: begin align_q <= rsp_rdata[0]; nack_q <= nack_q | ~req_ack; end
          S_WR_TPS, S_WR_CLR: tps_now_q <= wdata;
          default: ;
        endcase
      end
    end
  end

  assign link_trained = (st_q == S_OK);
  assign train_failed = (st_q == S_FAIL);
  assign rate_idx     = rate_q;

endmodule

// File: rtl/lt_seq_chk.sv
module lt_seq_chk #(
  parameter int ADDR_W    = 20,
  parameter int MAX_POLLS = 5,
  parameter int CNT_W     = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [7:0]        req_wdata,
  input logic              req_done,
  input logic              link_trained,
  input logic              train_failed,
  input logic [1:0]        rate_idx,
  input logic [7:0]        tps_now,
  input logic [CNT_W-1:0]  poll_cnt,
  input logic              gap_ok,
  input logic              fallback_evt,
  input logic              start_evt
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_done) |=> (req_valid && $stable(req_write) && $stable(req_addr) && $stable(req_wdata))); // R10
  AST_READ_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(req_valid) && !req_write) |-> $past(gap_ok)); // R4
  AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    poll_cnt <= CNT_W'(MAX_POLLS)); // R7
  AST_CLEAR_BEFORE_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
    fallback_evt |-> (tps_now == 8'h00)); // R7
  AST_RATE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_idx != $past(rate_idx)) |-> ($past(start_evt) || rate_idx == $past(rate_idx) + 2'd1)); // R8
  AST_FAIL_AT_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(train_failed) |-> (rate_idx == 2'd2 && tps_now == 8'h00)); // R8
  AST_TRAINED_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_trained) |-> (tps_now == 8'h00)); // R9
  AST_VERDICT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(link_trained && train_failed)); // R12
endmodule

bind link_train_seq lt_seq_chk #(.ADDR_W(ADDR_W), .MAX_POLLS(MAX_POLLS), .CNT_W(CNT_W)) u_chk (
  .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_write (req_write),
  .req_addr (req_addr), .req_wdata (req_wdata), .req_done (req_done),
  .link_trained (link_trained), .train_failed (train_failed), .rate_idx (rate_idx),
  .tps_now (tps_now_q), .poll_cnt (poll_cnt), .gap_ok (gap_ok),
  .fallback_evt (fallback_evt), .start_evt (start_evt)
);

// File: tb/link_train_seq_bench.sv
`timescale 1ns/1ps
module link_train_seq_bench;
  localparam int LAT = 2;

  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [2:0]  cfg_lanes = 3'd4, cfg_eq_tps = 3'd3;
  logic [1:0]  cfg_rate = 2'd0;
  logic [7:0]  poll_gap = 8'd4;
  logic        req_valid, req_write, req_done, req_ack;
  logic [19:0] req_addr;
  logic [7:0]  req_wdata, rsp_rdata;
  logic        link_trained, train_failed;
  logic [1:0]  rate_idx;

  link_train_seq u_link_train_seq (
    .clk, .rst_n, .start, .cfg_lanes, .cfg_rate, .cfg_eq_tps, .poll_gap,
    .req_valid, .req_write, .req_addr, .req_wdata, .req_done, .req_ack, .rsp_rdata,
    .link_trained, .train_failed, .rate_idx
  );

  initial forever #2.5 clk = ~clk;

  int n_checks = 0, n_fail = 0, cyc = 0;
  initial forever begin @(posedge clk); cyc++; end

  // scenario state and log
  int crn[3], eqn[3], lanes_i, eqp;
  bit nk;
  int tps_log[32], tps_n, rate_log[8], rate_n, lanes_wr, polls, bad_addr;
  int first_addr[3], n_tx, last_mark, min_gap, phase, pn, rcur;
  int exp_tps[32], exp_tn, exp_rates[8], exp_rn, exp_polls, exp_rate;
  bit exp_ok;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int rcode(input int r);
    return (r == 0) ? 'h14 : (r == 1) ? 'h0A : 'h06;
  endfunction

  function automatic logic [7:0] pack_pair(input int lo, input logic [3:0] nib);
    logic [3:0] m;
    m = (lanes_i == 1) ? 4'b0001 : (lanes_i == 2) ? 4'b0011 : 4'b1111;
    return {m[lo+1] ? nib : 4'h0, m[lo] ? nib : 4'h0};
  endfunction

  // responder: fixed latency, one-cycle done, status from per-phase poll count
  int wcnt = 0;
  initial begin
    req_done = 1'b0; req_ack = 1'b1; rsp_rdata = 8'h00;
    forever begin
      @(negedge clk);
      if (req_done) begin
        req_done = 1'b0; req_ack = 1'b1;
      end else if (rst_n && req_valid) begin
        if (wcnt == 0 && !req_write && req_addr == 20'h202 && (cyc - last_mark) < min_gap)
          min_gap = cyc - last_mark;
        wcnt++;
        if (wcnt >= LAT) begin
          logic cr, eqb;
          wcnt = 0;
          if (n_tx < 3) first_addr[n_tx] = int'(req_addr);
          n_tx++;
          req_ack = 1'b1;
          cr  = (phase == 1) || (pn >= crn[rcur]);
          eqb = (phase == 1) && (pn >= eqn[rcur]);
          if (req_write) begin
            case (req_addr)
              20'h100: begin
                rate_log[rate_n++] = req_wdata;
                rcur = (req_wdata == 8'h14) ? 0 : (req_wdata == 8'h0A) ? 1 : 2;
              end
              20'h101: lanes_wr = req_wdata;
              20'h102: begin
                tps_log[tps_n++] = req_wdata;
                last_mark = cyc;
                if (req_wdata == 8'd1) begin phase = 0; pn = 0; end
                else if (req_wdata != 8'd0) begin phase = 1; pn = 0; end
              end
              default: bad_addr++;
            endcase
          end else begin
            case (req_addr)
              20'h202: begin
                pn++; polls++;
                cr  = (phase == 1) || (pn >= crn[rcur]);
                eqb = (phase == 1) && (pn >= eqn[rcur]);
                rsp_rdata = pack_pair(0, {1'b0, eqb, eqb, cr});
              end
              20'h203: begin
                rsp_rdata = pack_pair(2, {1'b0, eqb, eqb, cr});
                if (nk && phase == 0 && pn == 1) req_ack = 1'b0;
              end
              20'h204: begin rsp_rdata = {7'd0, eqb}; last_mark = cyc; end
              default: bad_addr++;
            endcase
          end
          req_done = 1'b1;
        end
      end
    end
  end

  task automatic run(input int ln, input int r0, input int ep, input int c0, input int c1,
                     input int c2, input int e0, input int e1, input int e2, input bit nack,
                     input int gap);
    int ce, w;
    lanes_i = ln; eqp = ep; nk = nack;
    crn[0] = c0; crn[1] = c1; crn[2] = c2; eqn[0] = e0; eqn[1] = e1; eqn[2] = e2;
    tps_n = 0; rate_n = 0; lanes_wr = -1; polls = 0; bad_addr = 0; n_tx = 0;
    min_gap = 1000000; phase = 0; pn = 0; rcur = r0; last_mark = cyc;
    // expected from the requirements
    exp_tn = 0; exp_rn = 0; exp_polls = 0; exp_ok = 0; exp_rate = 2;
    for (int r = r0; r < 3; r++) begin
      exp_rates[exp_rn++] = rcode(r);
      exp_tps[exp_tn++] = 1;
      ce = (nack && crn[r] < 2) ? 2 : crn[r];
      if (ce <= 5) begin
        exp_polls += ce;
        exp_tps[exp_tn++] = (ep >= 2 && ep <= 4) ? ep : 3;
        if (eqn[r] <= 5) begin
          exp_polls += eqn[r]; exp_tps[exp_tn++] = 0; exp_ok = 1; exp_rate = r;
          break;
        end
        exp_polls += 5; exp_tps[exp_tn++] = 0;
      end else begin
        exp_polls += 5; exp_tps[exp_tn++] = 0;
      end
    end
    @(negedge clk);
    cfg_lanes = 3'(ln); cfg_rate = 2'(r0); cfg_eq_tps = 3'(ep); poll_gap = 8'(gap);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(!link_trained && !train_failed, "R12 start clears verdict", link_trained + train_failed, 0);
    w = 0;
    while (!(link_trained || train_failed) && w < 20000) begin @(negedge clk); w++; end
    check(w < 20000, "R8 watchdog per run", w, 20000);
    check(link_trained == exp_ok, "R9 trained verdict", link_trained, exp_ok);
    check(train_failed == !exp_ok, "R8 failed verdict", train_failed, !exp_ok);
    check(rate_idx == exp_rate, "R8 final rate index", rate_idx, exp_rate);
    check(rate_n == exp_rn, "R2 R8 rate write count", rate_n, exp_rn);
    for (int i = 0; i < exp_rn && i < rate_n; i++)
      check(rate_log[i] == exp_rates[i], "R2 R8 rate code order", rate_log[i], exp_rates[i]);
    check(first_addr[0] == 'h100 && first_addr[1] == 'h101 && first_addr[2] == 'h102,
          "R2 config before pattern", first_addr[1], 'h101);
    check(lanes_wr == ln, "R2 lane count written", lanes_wr, ln);
    check(tps_n == exp_tn, "R3 R6 R7 R9 pattern write count", tps_n, exp_tn);
    for (int i = 0; i < exp_tn && i < tps_n; i++)
      check(tps_log[i] == exp_tps[i], "R3 R6 R7 R9 pattern order", tps_log[i], exp_tps[i]);
    check(polls == exp_polls, "R5 R7 R11 poll count", polls, exp_polls);
    check(bad_addr == 0, "R5 unexpected address", bad_addr, 0);
    check(min_gap >= gap, "R4 status read gap", min_gap, gap);
    repeat (10) @(negedge clk);
    check(link_trained == exp_ok && train_failed == !exp_ok && !req_valid,
          "R12 verdict holds", link_trained, exp_ok);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!link_trained && !train_failed && !req_valid, "R1 reset state", req_valid, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(!req_valid && !link_trained && !train_failed, "R1 idle without start", req_valid, 0);
    // directed cases
    run(4, 0, 3, 1, 1, 1, 1, 1, 1, 0, 4);   // immediate success at top rate
    run(4, 0, 3, 6, 2, 1, 3, 3, 1, 0, 3);   // no clock recovery at 5.4, trains at 2.7
    run(2, 0, 3, 6, 6, 6, 1, 1, 1, 0, 5);   // fails at every rate
    run(1, 0, 2, 5, 5, 1, 6, 5, 1, 0, 2);   // boundary: 5th poll passes, EQ falls back
    run(4, 0, 4, 1, 1, 1, 2, 1, 1, 1, 3);   // R11: NACK on first CR poll
    run(4, 2, 3, 1, 1, 3, 1, 1, 6, 0, 3);   // start at 1.62, EQ failure
    run(2, 1, 7, 1, 1, 1, 1, 1, 1, 0, 6);   // illegal EQ pattern selects 3
    // sweep over lane count and the per-phase need at the top rate
    for (int l = 0; l < 3; l++)
      for (int c = 4; c <= 6; c++)
        for (int e = 4; e <= 6; e++)
          run((l == 0) ? 1 : (l == 1) ? 2 : 4, 0, 3, c, 2, 1, e, 2, 1, (c == 4), 3);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    wait (cyc > 190000);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule